// File: doc/BRIEF.md
# Register-Mapped Serial Port with Transmit and Receive Queues

This block is a full-duplex asynchronous serial port that a host drives through a plain 32-bit register read/write strobe interface, the kind of interface the user side of a programmed-I/O bridge presents. A host write to the data register places a character in a 16-entry transmit queue. The transmitter takes characters from that queue and sends each one on the serial output. It adds the start, odd-parity and stop bits itself. Characters that arrive on the serial input are checked and have their framing removed. They then wait in a 16-entry receive queue until the host reads them.

The bit rate comes from a separate baud clock. That clock is sampled into the system clock domain, and a fractional phase accumulator turns its rising edges into 16x-oversample ticks. With the default ratio of 3/40 applied to a 24.576 MHz baud clock, the tick rate is exactly 16 x 115200 Hz. Each character is carried in the most significant byte lane of the 32-bit word, and the other lanes read as zero. A status word reports whether receive data is waiting, whether the transmit queue is full, and three error flags: parity, overrun and framing. The error flags clear when the status word is read.

Top module: `uart_regbus`

## Requirements
- R1: After reset the serial output is high (idle), the status word reads 0x00000000 and a data register read returns 0x00000000.
- R2: A write to offset 0x10 sends bus_wdata[31:24] as one frame: a low start bit, 8 data bits least significant first, an odd parity bit (data plus parity hold an odd number of ones) and a high stop bit.
- R3: The transmit queue holds 16 characters besides the one being shifted out. The status word bit 1 reads 1 while the queue is full, and a write made while it is full is discarded.
- R4: Each received character is read from offset 0x10 as {char, 24'h000000}, and characters come out in arrival order.
- R5: A data read with an empty receive queue returns 0x00000000 and removes nothing.
- R6: A received frame whose parity is wrong sets status bit 2. The character is still queued, and reading the status word clears the bit.
- R7: A character that arrives while the receive queue holds 16 characters is dropped and sets status bit 3. The 16 characters already queued are kept.
- R8: A received frame whose stop bit samples low sets status bit 4. Reading the status word clears it.
- R9: Writes to any offset other than 0x10 send nothing. Reads of any offset other than 0x10 and 0x14 return 0x00000000.
- R10: Each bit lasts 16 oversample ticks, and one tick occurs every ACC_MOD/ACC_INC rising edges of baud_clk on average.
- R11: Transmission and reception run at the same time without disturbing each other.
- R12: Status bit 0 reads 1 exactly when the receive queue holds at least one character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all register logic |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_clk | input | 1 | Free-running baud reference clock, at most a third of clk |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data; character in bits 31:24 |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd and held until the next read |
| ser_txd | output | 1 | Serial output, high when idle |
| ser_rxd | input | 1 | Serial input |

## Verification
The bench fills the transmit queue past its limit. A design with an off-by-one in the full test would lose the 17th character or send an 18th. The bench also overruns the receive queue, where a wrong design would let the late character overwrite the oldest one or appear out of order. Frames with a deliberately wrong parity bit and a low stop bit check that the sticky flags set and clear on a status read. A receiver that re-triggered on the still-low line after a bad stop bit would report a phantom character. Empty-queue and unmapped reads catch a design that pops or returns stale data. The bench times an all-zero character's low stretch, which exposes a wrong tick divisor. It also runs transmit and receive frames at the same time, which exposes shared state between the two directions.

// File: rtl/uart_pkg.sv
// Shared constants and types for the register-mapped serial port.
package uart_pkg;
    // Line state used by both framers
    typedef enum logic [2:0] {
        LS_IDLE,
        LS_START,
        LS_DATA,
        LS_PAR,
        LS_STOP
    } line_state_t;

    localparam int unsigned TICKS_PER_BIT = 16;
    localparam int unsigned HALF_BIT      = TICKS_PER_BIT / 2;
    localparam int unsigned CHAR_W        = 8;

    // Status word bit positions
    localparam int unsigned ST_RX_AVAIL = 0;
    localparam int unsigned ST_TX_FULL  = 1;
    localparam int unsigned ST_PAR_BAD  = 2;
    localparam int unsigned ST_OVERRUN  = 3;
    localparam int unsigned ST_FRM_BAD  = 4;
endpackage

// File: rtl/uart_baud_tick.sv
// Oversample tick generator.
// Brings baud_clk into the clk domain with a 2-flop synchronizer and
// finds its rising edges. A phase accumulator adds ACC_INC on every
// edge and emits a one-cycle tick whenever it passes ACC_MOD.
// Assumes clk runs at least three times faster than baud_clk.
module uart_baud_tick #(
    parameter int unsigned ACC_INC = 3,
    parameter int unsigned ACC_MOD = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic baud_clk,
    output logic tick
);
    localparam int unsigned AW = $clog2(ACC_MOD + ACC_INC + 1);

    logic [2:0]    bsync;
    logic          b_edge;
    logic [AW-1:0] acc;
    logic [AW-1:0] acc_sum;

    // Synchronize the baud reference and keep one older sample
    always_ff @(posedge clk) begin
        if (!rst_n) bsync <= 3'b000;
        else        bsync <= {bsync[1:0], baud_clk};
    end

    assign b_edge  = bsync[1] & ~bsync[2];
    assign acc_sum = acc + AW'(ACC_INC);

    // Advance the fractional phase on each baud edge, tick on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (b_edge) begin
                if (acc_sum >= AW'(ACC_MOD)) begin
                    acc  <= acc_sum - AW'(ACC_MOD);
                    tick <= 1'b1;
                end else begin
                    acc <= acc_sum;
                end
            end
        end
    end

    // R10: ticks come from separate baud edges, so two never touch
    a_r10_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    // R10: a tick only follows a cycle that saw a baud edge
    a_r10_tick_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(b_edge));
endmodule

// File: rtl/uart_fifo.sv
// Synchronous queue of DEPTH words of W bits with a show-ahead read port.
// A push while full is discarded, and so is a pop while empty.
// Any DEPTH is handled; the pointers wrap explicitly.
module uart_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push_ok, pop_ok;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign rdata   = mem[rp];

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push_ok) wp <= ptr_next(wp);
            if (pop_ok)  rp <= ptr_next(rp);
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R3/R7: occupancy never exceeds the depth
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    // R3/R7: a push into a full queue without a pop changes nothing
    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full && (wp == $past(wp)));
endmodule

// File: rtl/uart_tx_framer.sv
// Transmit framer.
// Takes one character from the transmit queue whenever it is idle and
// the queue is not empty. It then drives a start bit, 8 data bits
// least significant first, an odd parity bit and a stop bit, each
// lasting TICKS_PER_BIT oversample ticks.
// The output is high whenever no frame is in progress.
module uart_tx_framer
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              q_empty,
    input  logic [CHAR_W-1:0] q_data,
    output logic              q_pop,
    output logic              txd
);
    line_state_t       st;
    logic [3:0]        tcnt;
    logic [2:0]        bidx;
    logic [CHAR_W-1:0] sh;
    logic              par;

    assign q_pop = (st == LS_IDLE) && !q_empty;

    // Frame sequencer: load from the queue, then step bit by bit on ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= LS_IDLE;
            tcnt <= '0;
            bidx <= '0;
            sh   <= '0;
            par  <= 1'b0;
        end else if (st == LS_IDLE) begin
            if (!q_empty) begin
                st   <= LS_START;
                sh   <= q_data;
                par  <= ~^q_data;
                tcnt <= '0;
                bidx <= '0;
            end
        end else if (tick) begin
            if (tcnt == 4'(TICKS_PER_BIT - 1)) begin
                tcnt <= '0;
                case (st)
                    LS_START: st <= LS_DATA;
                    LS_DATA: begin
                        sh   <= sh >> 1;
                        bidx <= bidx + 1'b1;
                        if (bidx == 3'd7) st <= LS_PAR;
                    end
                    LS_PAR:  st <= LS_STOP;
                    default: st <= LS_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // Line level for the current bit
    always_comb begin
        case (st)
            LS_START: txd = 1'b0;
            LS_DATA:  txd = sh[0];
            LS_PAR:   txd = par;
            default:  txd = 1'b1;
        endcase
    end

    // R2: a start bit follows every character taken from the queue
    a_r2_start_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> !txd);
    // R1: with nothing to send, the line stays idle high
    a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (st == LS_IDLE && q_empty) |=> txd);
endmodule

// File: rtl/uart_rx_framer.sv
// Receive framer.
// Synchronizes the serial input and waits for a falling edge, which it
// confirms as a start bit half a bit later. It then samples each data
// bit, the parity bit and the stop bit at the centre of the bit. At the
// stop-bit centre it issues a one-cycle character strobe together with
// the parity and framing results.
// Only a falling edge starts a frame, so a line held low does not.
module uart_rx_framer
    import uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    output logic              chr_vld,
    output logic [CHAR_W-1:0] chr,
    output logic              par_bad,
    output logic              stop_bad
);
    line_state_t       st;
    logic [2:0]        rs;
    logic              rx_s, fall;
    logic [3:0]        tcnt;
    logic [2:0]        bidx;
    logic [CHAR_W-1:0] sh;
    logic              pbit;

    // Input synchronizer plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rs <= 3'b111;
        else        rs <= {rs[1:0], rxd};
    end

    assign rx_s = rs[1];
    assign fall = rs[2] & ~rs[1];

    // Frame sequencer sampling at bit centres
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= LS_IDLE;
            tcnt     <= '0;
            bidx     <= '0;
            sh       <= '0;
            pbit     <= 1'b0;
            chr_vld  <= 1'b0;
            chr      <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            chr_vld <= 1'b0;
            case (st)
                LS_IDLE: begin
                    if (fall) begin
                        st   <= LS_START;
                        tcnt <= '0;
                    end
                end
                LS_START: begin
                    if (tick) begin
                        if (tcnt == 4'(HALF_BIT - 1)) begin
                            tcnt <= '0;
                            bidx <= '0;
                            st   <= rx_s ? LS_IDLE : LS_DATA;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (tcnt == 4'(TICKS_PER_BIT - 1)) begin
                            tcnt <= '0;
                            if (st == LS_DATA) begin
                                sh   <= {rx_s, sh[CHAR_W-1:1]};
                                bidx <= bidx + 1'b1;
                                if (bidx == 3'd7) st <= LS_PAR;
                            end else if (st == LS_PAR) begin
                                pbit <= rx_s;
                                st   <= LS_STOP;
                            end else begin
                                chr_vld  <= 1'b1;
                                chr      <= sh;
                                par_bad  <= ~(^{sh, pbit});
                                stop_bad <= ~rx_s;
                                st       <= LS_IDLE;
                            end
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R4: one strobe per frame, never on back-to-back cycles
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |=> !chr_vld);
    // R4: a strobe is only issued on an oversample tick
    a_r4_strobe_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        chr_vld |-> $past(tick));
endmodule

// File: rtl/uart_regbus.sv
// Register-mapped serial port, top level.
// Decodes single-cycle read and write strobes into a data register at
// DATA_OFS and a status word at STAT_OFS.
// - Writes to the data register queue bus_wdata[31:24] for transmit.
// - Reads of the data register pop the receive queue. An empty queue
//   reads as zero.
// - Reading the status word clears its sticky error flags.
// Read data is registered: it is valid the cycle after bus_rd.
module uart_regbus
    import uart_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 8,
    parameter int unsigned       Q_DEPTH  = 16,
    parameter int unsigned       ACC_INC  = 3,
    parameter int unsigned       ACC_MOD  = 40,
    parameter logic [ADDR_W-1:0] DATA_OFS = ADDR_W'(8'h10),
    parameter logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(8'h14)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_clk,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              ser_txd,
    input  logic              ser_rxd
);
    localparam int unsigned LANE_LO = 32 - CHAR_W;

    logic              tick;
    logic              txq_pop, txq_full, txq_empty;
    logic [CHAR_W-1:0] txq_data;
    logic              rxq_push, rxq_pop, rxq_full, rxq_empty;
    logic [CHAR_W-1:0] rxq_data;
    logic              rx_vld, rx_par_bad, rx_stop_bad;
    logic [CHAR_W-1:0] rx_chr;
    logic              sel_data, sel_stat;
    logic              stk_par, stk_ovr, stk_frm, stat_clr;
    logic [31:0]       stat_word;

    assign sel_data = (bus_addr == DATA_OFS);
    assign sel_stat = (bus_addr == STAT_OFS);
    assign rxq_push = rx_vld;
    assign rxq_pop  = bus_rd && sel_data && !rxq_empty;
    assign stat_clr = bus_rd && sel_stat;

    uart_baud_tick #(.ACC_INC(ACC_INC), .ACC_MOD(ACC_MOD)) tick_i (
        .clk(clk), .rst_n(rst_n), .baud_clk(baud_clk), .tick(tick));

    uart_fifo #(.DEPTH(Q_DEPTH), .W(CHAR_W)) txq_i (
        .clk(clk), .rst_n(rst_n),
        .push(bus_wr && sel_data), .wdata(bus_wdata[31:LANE_LO]),
        .pop(txq_pop), .rdata(txq_data), .full(txq_full), .empty(txq_empty));

    uart_tx_framer tx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .q_empty(txq_empty), .q_data(txq_data), .q_pop(txq_pop), .txd(ser_txd));

    uart_rx_framer rx_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(ser_rxd),
        .chr_vld(rx_vld), .chr(rx_chr), .par_bad(rx_par_bad), .stop_bad(rx_stop_bad));

    uart_fifo #(.DEPTH(Q_DEPTH), .W(CHAR_W)) rxq_i (
        .clk(clk), .rst_n(rst_n),
        .push(rxq_push), .wdata(rx_chr),
        .pop(rxq_pop), .rdata(rxq_data), .full(rxq_full), .empty(rxq_empty));

    // Sticky error flags: a new event wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stk_par <= 1'b0;
            stk_ovr <= 1'b0;
            stk_frm <= 1'b0;
        end else begin
            stk_par <= (rx_vld && rx_par_bad)  || (stk_par && !stat_clr);
            stk_frm <= (rx_vld && rx_stop_bad) || (stk_frm && !stat_clr);
            stk_ovr <= (rx_vld && rxq_full)    || (stk_ovr && !stat_clr);
        end
    end

    // Assemble the status word from live and sticky flags
    always_comb begin
        stat_word              = '0;
        stat_word[ST_RX_AVAIL] = !rxq_empty;
        stat_word[ST_TX_FULL]  = txq_full;
        stat_word[ST_PAR_BAD]  = stk_par;
        stat_word[ST_OVERRUN]  = stk_ovr;
        stat_word[ST_FRM_BAD]  = stk_frm;
    end

    // Registered read data, held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (sel_data)      bus_rdata <= rxq_empty ? '0 : {rxq_data, {LANE_LO{1'b0}}};
            else if (sel_stat) bus_rdata <= stat_word;
            else               bus_rdata <= '0;
        end
    end

    // R5: a data read on an empty queue returns zero
    a_r5_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_data && rxq_empty) |=> (bus_rdata == '0));
    // R9: reads of unmapped offsets return zero
    a_r9_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !sel_data && !sel_stat) |=> (bus_rdata == '0));
    // R4: data reads only ever carry the low three byte lanes as zero
    a_r4_low_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel_data) |=> (bus_rdata[LANE_LO-1:0] == '0));
    // R7: an arrival into a full receive queue raises overrun next cycle
    a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rxq_full) |=> stk_ovr);
endmodule

// File: tb/uart_regbus_tb_top.sv
// Self-checking bench for uart_regbus with a shortened tick ratio.
module uart_regbus_tb_top;
    localparam int CLK_HALF = 4;                    // 125 MHz
    localparam int BAUD_HALF = 20;                  // baud period 5 clk
    localparam int INC = 1;
    localparam int MOD = 2;
    localparam int BIT = 16 * (MOD / INC) * 5;      // 160 clk per bit
    localparam logic [7:0] A_DATA = 8'h10;
    localparam logic [7:0] A_STAT = 8'h14;
    localparam int NVEC = 6;
    // [15:8] character sent by host, [7:0] character arriving on the line
    localparam logic [15:0] VEC [NVEC] = '{
        16'h32_36, 16'h00_FF, 16'hFF_00, 16'hA5_5A, 16'h80_01, 16'h7E_C3
    };

    logic        clk = 1'b0, baud_clk = 1'b0, rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_txd;
    logic        ser_rxd = 1'b1;
    int          total = 0, bad = 0, cyc = 0;

    always #CLK_HALF clk = ~clk;
    always #BAUD_HALF baud_clk = ~baud_clk;

    uart_regbus #(.ACC_INC(INC), .ACC_MOD(MOD)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_clk(baud_clk),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_txd(ser_txd), .ser_rxd(ser_rxd));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<190000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic line_bit(input logic v);
        ser_rxd = v;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input bit flip_par, input bit low_stop);
        @(negedge clk);
        line_bit(1'b0);
        for (int i = 0; i < 8; i++) line_bit(b[i]);
        line_bit((~^b) ^ flip_par);
        line_bit(!low_stop);
        line_bit(1'b1);
    endtask

    // Wait for a start bit and sample every bit at its centre
    task automatic grab_tx(output logic [7:0] d, output logic p, output logic s, output logic st0);
        @(negedge clk);
        while (ser_txd) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        st0 = ser_txd;
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            d[i] = ser_txd;
        end
        repeat (BIT) @(negedge clk);
        p = ser_txd;
        repeat (BIT) @(negedge clk);
        s = ser_txd;
    endtask

    initial begin
        logic [31:0] rd;
        logic [7:0]  d;
        logic        p, s, st0;
        bit          stayed;
        int          lowlen;

        // Reset state (R1)
        repeat (5) @(negedge clk);
        chk(ser_txd === 1'b1, "R1 idle line in reset", 32'(ser_txd), 32'h1);
        rst_n = 1'b1;
        bus_read(A_STAT, rd);
        chk(rd === 32'h0, "R1 status after reset", rd, 32'h0);
        bus_read(A_DATA, rd);
        chk(rd === 32'h0, "R1 R5 empty data read", rd, 32'h0);
        bus_read(A_STAT, rd);
        chk(rd === 32'h0, "R12 still empty after empty read", rd, 32'h0);

        // Vector table: host send and line receive at once (R2 R4 R11)
        for (int i = 0; i < NVEC; i++) begin
            fork
                send_rx(VEC[i][7:0], 1'b0, 1'b0);
                begin
                    bus_write(A_DATA, {VEC[i][15:8], 24'h0});
                    grab_tx(d, p, s, st0);
                end
            join
            chk(st0 === 1'b0, "R2 start bit low", 32'(st0), 32'h0);
            chk(d === VEC[i][15:8], "R2 R11 sent character", 32'(d), 32'(VEC[i][15:8]));
            chk(p === ~^VEC[i][15:8], "R2 odd parity", 32'(p), 32'(~^VEC[i][15:8]));
            chk(s === 1'b1, "R2 stop bit high", 32'(s), 32'h1);
            bus_read(A_STAT, rd);
            chk(rd === 32'h1, "R12 status with one char", rd, 32'h1);
            bus_read(A_DATA, rd);
            chk(rd === {VEC[i][7:0], 24'h0}, "R4 R11 received word", rd, {VEC[i][7:0], 24'h0});
        end

        // Bit timing: 0x00 is low for start plus 8 data bits (R10)
        bus_write(A_DATA, 32'h0);
        @(negedge clk);
        while (ser_txd) @(negedge clk);
        lowlen = 0;
        while (!ser_txd) begin
            @(negedge clk);
            lowlen++;
        end
        chk(lowlen >= 9 * BIT - 15 && lowlen <= 9 * BIT + 5, "R10 low stretch length",
            32'(lowlen), 32'(9 * BIT));
        repeat (3 * BIT) @(negedge clk);

        // Unmapped offsets (R9)
        bus_write(8'h18, 32'h41000000);
        bus_write(A_STAT, 32'h42000000);
        stayed = 1'b1;
        repeat (2 * BIT) begin
            @(negedge clk);
            if (!ser_txd) stayed = 1'b0;
        end
        chk(stayed, "R9 unmapped writes send nothing", 32'(stayed), 32'h1);
        bus_read(8'h18, rd);
        chk(rd === 32'h0, "R9 unmapped read", rd, 32'h0);

        // Parity error (R6)
        send_rx(8'h55, 1'b1, 1'b0);
        bus_read(A_STAT, rd);
        chk(rd === 32'h5, "R6 parity flag set", rd, 32'h5);
        bus_read(A_STAT, rd);
        chk(rd === 32'h1, "R6 parity flag cleared", rd, 32'h1);
        bus_read(A_DATA, rd);
        chk(rd === 32'h55000000, "R6 char still queued", rd, 32'h55000000);

        // Framing error, then no phantom character (R8)
        send_rx(8'h3C, 1'b0, 1'b1);
        repeat (2 * BIT) @(negedge clk);
        bus_read(A_STAT, rd);
        chk(rd === 32'h11, "R8 framing flag set", rd, 32'h11);
        bus_read(A_DATA, rd);
        chk(rd === 32'h3C000000, "R8 char queued", rd, 32'h3C000000);
        bus_read(A_STAT, rd);
        chk(rd === 32'h0, "R8 flag cleared, no phantom char", rd, 32'h0);

        // Receive overrun (R7)
        for (int i = 0; i < 17; i++) send_rx(8'(8'h10 + i), 1'b0, 1'b0);
        bus_read(A_STAT, rd);
        chk(rd === 32'h9, "R7 overrun flag", rd, 32'h9);
        for (int i = 0; i < 16; i++) begin
            bus_read(A_DATA, rd);
            chk(rd === {8'(8'h10 + i), 24'h0}, "R7 R4 kept order", rd, {8'(8'h10 + i), 24'h0});
        end
        bus_read(A_DATA, rd);
        chk(rd === 32'h0, "R7 R5 late char dropped", rd, 32'h0);
        bus_read(A_STAT, rd);
        chk(rd === 32'h0, "R12 R7 status empty and cleared", rd, 32'h0);

        // Transmit queue full (R3)
        fork
            begin
                for (int i = 0; i < 18; i++) bus_write(A_DATA, {8'(8'hC0 + i), 24'h0});
                bus_read(A_STAT, rd);
                chk(rd === 32'h2, "R3 full flag", rd, 32'h2);
            end
            begin
                for (int i = 0; i < 17; i++) begin
                    grab_tx(d, p, s, st0);
                    chk(d === 8'(8'hC0 + i), "R3 queued char sent", 32'(d), 32'(8'hC0 + i));
                end
            end
        join
        stayed = 1'b1;
        repeat (3 * BIT) begin
            @(negedge clk);
            if (!ser_txd) stayed = 1'b0;
        end
        chk(stayed, "R3 write while full discarded", 32'(stayed), 32'h1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule